// File: doc/BRIEF.md
# Velocity Key Matrix Scanner

This block walks an 8 by 8 keyboard matrix in which every key carries two contacts: a break contact that is closed while the key is up, and a make contact that closes at the bottom of its travel. One column line at a time is driven high, and the two row buses (break rows and make rows) are read back for the key at the current address. A single bit per key remembers whether that key was between its contacts on the previous visit. That bit, together with the two live contact levels, gives a three-bit status that tells a host whether the key has just started moving, is travelling, has just arrived at the bottom, or has just come back to rest. A host can time the travel from these events to get key velocity.

When a key needs attention, the scanner stops on it, keeps its column driven, and raises `irq`. The host reads the key address and status and then pulses `addr_rd`, which moves the scan on to the next key. An 8-bit prescaler sets how long each key is dwelt on, and therefore the scan period. A 2-bit range select lets the block serve as an expansion section of a larger keyboard: keys whose keyboard-wide index lies beyond the chosen note count are passed over without driving or sampling.

The controller has two states. DWELL counts out the settling time of the current key. At the end of that time it samples, classifies and either takes the ADVANCE transition (next address, stay in DWELL) or the STOP transition into HALT. HALT waits for `addr_rd` and then takes the RELEASE transition back into DWELL on the next address.

Top module: `velo_key_scanner`

## Requirements
- R1: After reset the key address is 0, `irq` is low, `key_status` is 3'b001, every stored travel bit is 0, and with range select 2'b00 the column output is 8'h01.
- R2: The key address is split as column = address[5:3] and row = address[2:0]; `col_drv` is one-hot on the column of the current key while that key is in range, and all zero otherwise.
- R3: In DWELL each key is held for exactly (prescale+1)*16 clock cycles, after which the address steps by one, wrapping from 63 to 0, so a scan without stops takes (prescale+1)*1024 cycles.
- R4: At the last cycle of a dwell the break level `row_nc[row]` and make level `row_no[row]` are sampled and `key_status` is loaded with {stored travel bit, make level, break level}, i.e. bit 2 = previous-travel, bit 1 = make, bit 0 = break.
- R5: A sampled in-range key requests service when its stored travel bit is 1 or both of its contacts read 0; the scanner then enters HALT, `irq` goes high, and the address and column stay on that key. Keys reading 3'b001 (rest) or 3'b010 (held down) make no request.
- R6: In HALT a one-cycle `addr_rd` pulse returns to DWELL on the next address with `irq` low from the following cycle; `addr_rd` in DWELL has no effect on the address or the dwell length.
- R7: Each sampled in-range key has its travel bit rewritten to 1 when both contacts read 0 and to 0 otherwise; the new bit is the one reported on the next visit to that key.
- R8: With a section base of 64, range select 2'b00 scans all keys, while 2'b01, 2'b10 and 2'b11 limit the section to keys 0..8, 0..11 and 0..23 (73, 76 and 88 notes keyboard-wide); other keys are dwelt on for the normal time but get no column drive, no sample, no travel-bit update and no request.
- R9: While in HALT `key_status` and `key_addr` do not change, whatever the row inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| prescale | input | 8 | Dwell divider N; each key is held (N+1)*16 cycles |
| mode | input | 2 | Range select: 00 all, 01 73 notes, 10 76 notes, 11 88 notes |
| row_nc | input | 8 | Break-contact row levels, active high |
| row_no | input | 8 | Make-contact row levels, active high |
| addr_rd | input | 1 | Host has read the address; releases a halt |
| col_drv | output | 8 | Active-high column drives |
| key_addr | output | 6 | Address of the current (or halted) key |
| key_status | output | 3 | Last sampled status {travel, make, break} |
| irq | output | 1 | High while halted on a key needing service |

## Verification
The assertions take for granted that `addr_rd` is a single-cycle pulse issued only in reply to `irq`, and that `prescale` and `mode` change only near the start of a key's dwell; the bench changes them only at the wrap to address 0 and pulses `addr_rd` for exactly one cycle. The stray `addr_rd` pulses used for the ignore case are issued only on a key known not to stop, and the row levels flipped during a halt are restored before the release, so the matrix the scanner samples is always the one the bench model holds for that scan.

// File: rtl/vks_pkg.sv
package vks_pkg;

    typedef enum logic {
        ST_DWELL = 1'b0,
        ST_HALT  = 1'b1
    } scan_state_t;

    localparam int unsigned NOTES_R1 = 73;
    localparam int unsigned NOTES_R2 = 76;
    localparam int unsigned NOTES_R3 = 88;

    // Keyboard-wide index below the note count of the selected range.
    function automatic logic key_in_range(input logic [1:0] sel,
                                          input int unsigned key_idx);
        logic ok;
        unique case (sel)
            2'b00:   ok = 1'b1;
            2'b01:   ok = (key_idx < NOTES_R1);
            2'b10:   ok = (key_idx < NOTES_R2);
            default: ok = (key_idx < NOTES_R3);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/vks_classify.sv
module vks_classify (
    input  logic       lt_prev,
    input  logic       make_lvl,
    input  logic       break_lvl,
    output logic [2:0] status,
    output logic       req,
    output logic       lt_next
);
    always_comb begin
        status  = {lt_prev, make_lvl, break_lvl};
        lt_next = ~make_lvl & ~break_lvl;
        req     = lt_prev | lt_next;
    end
endmodule

// File: rtl/vks_dwell_timer.sv
module vks_dwell_timer #(
    parameter int PRESCALE_W = 8,
    parameter int SUB_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [PRESCALE_W-1:0] prescale,
    output logic                  last
);
    localparam int CNT_W = PRESCALE_W + SUB_W;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q >= {prescale, {SUB_W{1'b1}}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_ONE;
    end
endmodule

// File: rtl/vks_lt_store.sv
module vks_lt_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic          rd_bit,
    input  logic          we,
    input  logic          wr_bit
);
    logic [DEPTH-1:0] bits_q;

    assign rd_bit = bits_q[addr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits_q[i] <= 1'b0;
            else if (we && (addr == AW'(i)))
                bits_q[i] <= wr_bit;
        end
    end
endmodule

// File: rtl/velo_key_scanner.sv
module velo_key_scanner #(
    parameter int          COLS         = 8,
    parameter int          ROWS         = 8,
    parameter int          PRESCALE_W   = 8,
    parameter int          SCAN_UNIT    = 1024,
    parameter int unsigned SECTION_BASE = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PRESCALE_W-1:0]         prescale,
    input  logic [1:0]                    mode,
    input  logic [ROWS-1:0]               row_nc,
    input  logic [ROWS-1:0]               row_no,
    input  logic                          addr_rd,
    output logic [COLS-1:0]               col_drv,
    output logic [$clog2(COLS*ROWS)-1:0]  key_addr,
    output logic [2:0]                    key_status,
    output logic                          irq
);
    import vks_pkg::*;

    localparam int KEYS  = COLS * ROWS;
    localparam int AW    = $clog2(KEYS);
    localparam int RW    = $clog2(ROWS);
    localparam int SUB_W = $clog2(SCAN_UNIT / KEYS);
    localparam logic [AW-1:0] ADDR_ONE = 1;

    scan_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [2:0]    status_q;

    logic          in_range;
    logic          dwell_last;
    logic          lt_prev, lt_next, cls_req;
    logic [2:0]    cls_status;
    logic          advance, capture;
    logic [RW-1:0] row_sel;

    assign in_range = key_in_range(mode, SECTION_BASE + 32'(addr_q));
    assign row_sel  = addr_q[RW-1:0];

    vks_dwell_timer #(
        .PRESCALE_W (PRESCALE_W),
        .SUB_W      (SUB_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_DWELL),
        .prescale (prescale),
        .last     (dwell_last)
    );

    vks_lt_store #(
        .DEPTH (KEYS),
        .AW    (AW)
    ) lt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr_q),
        .rd_bit (lt_prev),
        .we     (capture),
        .wr_bit (lt_next)
    );

    vks_classify cls_i (
        .lt_prev   (lt_prev),
        .make_lvl  (row_no[row_sel]),
        .break_lvl (row_nc[row_sel]),
        .status    (cls_status),
        .req       (cls_req),
        .lt_next   (lt_next)
    );

    // Transitions: ADVANCE, STOP, RELEASE
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_DWELL: begin
                if (dwell_last) begin
                    capture = in_range;
                    if (in_range && cls_req)
                        state_d = ST_HALT;
                    else
                        advance = 1'b1;
                end
            end
            ST_HALT: begin
                if (addr_rd) begin
                    state_d = ST_DWELL;
                    advance = 1'b1;
                end
            end
            default: state_d = ST_DWELL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_DWELL;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            status_q <= 3'b001;
        end else begin
            if (advance)
                addr_q <= addr_q + ADDR_ONE;
            if (capture)
                status_q <= cls_status;
        end
    end

    always_comb begin
        col_drv = '0;
        if (in_range)
            col_drv[addr_q[AW-1:RW]] = 1'b1;
        key_addr   = addr_q;
        key_status = status_q;
        irq        = (state_q == ST_HALT);
    end

endmodule

// File: rtl/velo_key_scanner_chk.sv
module velo_key_scanner_chk #(
    parameter int COLS = 8,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            addr_rd,
    input logic [COLS-1:0] col_drv,
    input logic [AW-1:0]   key_addr,
    input logic [2:0]      key_status,
    input logic            irq
);
    localparam logic [AW-1:0] ONE = 1;

    assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_drv));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_addr != $past(key_addr)) |-> (key_addr == $past(key_addr) + ONE));

    assert_stop_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (key_status[2] || (key_status[1:0] == 2'b00)));

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !addr_rd) |=> (irq && $stable(key_addr)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && addr_rd) |=> (!irq && (key_addr == $past(key_addr) + ONE)));

    assert_status_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !addr_rd) |=> $stable(key_status));

endmodule

bind velo_key_scanner velo_key_scanner_chk #(
    .COLS (COLS),
    .AW   (AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_rd    (addr_rd),
    .col_drv    (col_drv),
    .key_addr   (key_addr),
    .key_status (key_status),
    .irq        (irq)
);

// File: tb/velo_key_scanner_tb_top.sv
module velo_key_scanner_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prescale = 8'd0;
    logic [1:0] mode = 2'b00;
    logic [7:0] row_nc, row_no;
    logic       addr_rd = 1'b0;
    logic [7:0] col_drv;
    logic [5:0] key_addr;
    logic [2:0] key_status;
    logic       irq;

    logic [63:0] nc_m = '1;
    logic [63:0] no_m = '0;
    logic [63:0] lt_m = '0;

    int n_chk = 0, n_fail = 0;
    int last_addr = 0, dwell = 0;
    bit have_ref = 1'b0, stray = 1'b0, ended = 1'b0;

    always #4 clk = ~clk;

    velo_key_scanner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale   (prescale),
        .mode       (mode),
        .row_nc     (row_nc),
        .row_no     (row_no),
        .addr_rd    (addr_rd),
        .col_drv    (col_drv),
        .key_addr   (key_addr),
        .key_status (key_status),
        .irq        (irq)
    );

    // Diode matrix model: a row reads high if a driven column's key contact is closed.
    always_comb begin
        row_nc = '0;
        row_no = '0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                row_nc[r] = row_nc[r] | (col_drv[c] & nc_m[c*8+r]);
                row_no[r] = row_no[r] | (col_drv[c] & no_m[c*8+r]);
            end
    end

    function automatic bit in_rng(input logic [1:0] m, input int k);
        int g = 64 + k;
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return g < 73;
            2'b10:   return g < 76;
            default: return g < 88;
        endcase
    endfunction

    function automatic int exp_col(input int a);
        return in_rng(mode, a) ? (1 << (a >> 3)) : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_all(input bit nc, input bit no);
        nc_m = nc ? '1 : '0;
        no_m = no ? '1 : '0;
    endtask

    // Follows one full scan until the address wraps to 0.
    task automatic service_scan();
        bit fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            if (irq) begin
                int k = key_addr;
                bit er = in_rng(mode, k) && (lt_m[k] || (!no_m[k] && !nc_m[k]));
                int est = {lt_m[k], no_m[k], nc_m[k]};
                chk(er, "R5 stop on key needing service", k, 1);
                chk(k == last_addr, "R5 stop on current key", k, last_addr);
                chk(int'(key_status) == est, "R4/R7 status code", key_status, est);
                nc_m[k] = ~nc_m[k];
                repeat (3) @(negedge clk);
                chk(irq && key_addr == 6'(k) && int'(key_status) == est,
                    "R9 halt frozen", key_status, est);
                nc_m[k] = ~nc_m[k];
                addr_rd = 1'b1;
                @(negedge clk);
                addr_rd = 1'b0;
                chk(!irq && int'(key_addr) == (k + 1) % 64, "R6 release", key_addr, (k + 1) % 64);
                lt_m[k] = !no_m[k] && !nc_m[k];
                chk(int'(col_drv) == exp_col(key_addr), "R2 column", col_drv, exp_col(key_addr));
                if (k == 63) fin = 1'b1;
                last_addr = key_addr;
                dwell = 1;
                have_ref = 1'b1;
            end else begin
                addr_rd = (stray && key_addr == 6'd5);
                if (int'(key_addr) != last_addr) begin
                    int p = last_addr;
                    if (in_rng(mode, p)) begin
                        bit er = lt_m[p] || (!no_m[p] && !nc_m[p]);
                        chk(!er, "R5 no stop expected", er, 0);
                        lt_m[p] = !no_m[p] && !nc_m[p];
                    end
                    if (have_ref)
                        chk(dwell == 16 * (int'(prescale) + 1), "R3 dwell length",
                            dwell, 16 * (int'(prescale) + 1));
                    chk(int'(key_addr) == (p + 1) % 64, "R3 address step", key_addr, (p + 1) % 64);
                    chk(int'(col_drv) == exp_col(key_addr), "R2/R8 column", col_drv, exp_col(key_addr));
                    if (p == 63) fin = 1'b1;
                    last_addr = key_addr;
                    dwell = 1;
                    have_ref = 1'b1;
                end else begin
                    dwell++;
                end
            end
        end
        addr_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(key_addr == 6'd0, "R1 address", key_addr, 0);
        chk(!irq, "R1 irq", irq, 0);
        chk(col_drv == 8'h01, "R1 column", col_drv, 1);
        chk(key_status == 3'b001, "R1 status", key_status, 1);
        last_addr = 0;
        dwell = 2;
        have_ref = 1'b0;

        // R3/R6: all keys at rest, stray reads on key 5 must change nothing
        stray = 1'b1;
        service_scan();
        stray = 1'b0;

        // R4/R5: a few keys leave rest
        nc_m[0] = 0; nc_m[9] = 0; nc_m[27] = 0; nc_m[63] = 0;
        service_scan();
        // R7: arrivals, returns and continued travel
        no_m[0] = 1; nc_m[9] = 1; no_m[63] = 1; nc_m[40] = 0;
        service_scan();
        // held key makes no request; 27 arrives; 40 returns
        no_m[27] = 1; nc_m[40] = 1;
        service_scan();
        set_all(1'b1, 1'b0);
        service_scan();

        // Sweep every address through leave, arrive, hold
        set_all(1'b0, 1'b0);
        service_scan();
        set_all(1'b0, 1'b1);
        service_scan();
        service_scan();

        // R3: longer dwell
        prescale = 8'd2;
        set_all(1'b1, 1'b0);
        service_scan();
        prescale = 8'd0;

        // R8: note ranges
        mode = 2'b01;
        set_all(1'b0, 1'b0);
        service_scan();
        mode = 2'b10;
        service_scan();
        mode = 2'b11;
        set_all(1'b0, 1'b1);
        service_scan();
        mode = 2'b00;
        set_all(1'b1, 1'b0);
        service_scan();

        finish_run();
    end

endmodule